// File: doc/BRIEF.md
# Pulse Accumulator with Gated Time Mode

This block is a 16-bit accumulator fed from one timer input pin. It works in one of two modes. In event mode it counts one chosen edge of the pin, either rising or falling. In gated mode it counts ticks of an internal divide-by-64 clock enable for as long as the pin is held at a chosen active level. In gated mode it also raises a sticky flag when the gate closes.

The pin is first passed through a two-flop synchroniser. Edges and gate levels are judged only on the synchronised copy. Event counting has no dependence on the global timer enable. Gated counting and its prescaler run only while that enable is high.

Software works the block through three things: an 8-bit control register, a 16-bit count that it can write at any time, and two sticky flags that it clears by writing 1. The flags are counter overflow and gate-closed.

Top module: `pulse_accum`

## Requirements
- R1: The control register resets to 0x00. Only bits 6 (enable), 5 (mode) and 4 (edge/level select) store written values. Bit 7 and bits 3..0 always read 0, and writes to them are ignored.
- R2: While bit 6 is 0, the count changes only through a software count write, whatever the pin does.
- R3: In event mode (bit 5 = 0), each rising edge of the pin adds 1 to the count when bit 4 = 1, and each falling edge adds 1 when bit 4 = 0. The count changes on the third rising clock edge after the pin changes.
- R4: Event mode counts with the global timer enable low.
- R5: In gated mode (bit 5 = 1), the count adds 1 on each tick of a divide-by-64 enable while the synchronised pin is at its active level. The active level is high when bit 4 = 0 and low when bit 4 = 1. A gate held open for 256 cycles gathers 4 or 5 counts.
- R6: In gated mode with the global timer enable low, the count does not advance.
- R7: An increment from 0xFFFF to 0x0000 sets the overflow flag, and the flag stays set.
- R8: In gated mode with the block enabled, a change of the synchronised pin from active to inactive level sets the sticky input flag.
- R9: A flag-clear strobe clears the overflow flag when mask bit 0 is 1 and the input flag when mask bit 1 is 1. A flag whose mask bit is 0 is left unchanged. A set in the same cycle beats the clear.
- R10: A count write loads the written value on the next clock edge. If a write and an increment fall in the same cycle, the write wins and the overflow flag is not set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| timer_en_i | input | 1 | Global timer enable; gates the prescaler and gated counting |
| pin_i | input | 1 | Asynchronous timer input pin |
| ctrl_wr_i | input | 1 | Control register write strobe |
| ctrl_wdata_i | input | 8 | Control write data |
| ctrl_rdata_o | output | 8 | Control register contents |
| cnt_wr_i | input | 1 | Count write strobe |
| cnt_wdata_i | input | 16 | Count write data |
| cnt_o | output | 16 | Current count |
| flag_clr_i | input | 1 | Flag clear strobe |
| flag_clr_mask_i | input | 2 | Bit 0 clears overflow, bit 1 clears input flag |
| ovf_flag_o | output | 1 | Sticky overflow flag |
| in_flag_o | output | 1 | Sticky gate-closed flag |

## Verification
Two pairs of actions can land in one clock cycle.

The first pair is a software count write and a counted pin edge. The bench raises the pin and then asserts the write exactly two cycles later, so that both arrive at the same clock edge. It expects the written value and no overflow, even though the count started at 0xFFFF.

The second pair is a wrap that sets the overflow flag and a clear strobe aimed at that same flag. The bench arranges the same alignment and expects the flag to remain set.

A behavioural reference model, running alongside every clock, confirms all other cycles.

// File: rtl/pacc_pkg.sv
package pacc_pkg;

    localparam int CNT_W      = 16;
    localparam int CTRL_W     = 8;
    localparam int PRESCALE   = 64;
    localparam int SYNC_DEPTH = 2;

    // Writable control bits: enable, mode, select
    localparam logic [CTRL_W-1:0] CTRL_WMASK = 8'h70;

    typedef enum logic {
        MODE_EVENT = 1'b0,
        MODE_GATED = 1'b1
    } pacc_mode_e;

    typedef struct packed {
        logic       rsvd;
        logic       enable;
        pacc_mode_e mode;
        logic       sel;
        logic [3:0] unused;
    } pacc_ctrl_t;

    typedef struct packed {
        logic in_flag;
        logic ovf;
    } pacc_flags_t;

    function automatic pacc_ctrl_t ctrl_sanitize(input logic [CTRL_W-1:0] raw);
        return pacc_ctrl_t'(raw & CTRL_WMASK);
    endfunction

endpackage

// File: rtl/pacc_sync_edge.sv
module pacc_sync_edge #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic pin_i,
    output logic level_o,
    output logic prev_o
);
    localparam int LAST = STAGES;

    logic [LAST:0] sh_q;

    always_ff @(posedge clk) begin
        if (rst) sh_q <= '0;
        else     sh_q <= {sh_q[LAST-1:0], pin_i};
    end

    assign level_o = sh_q[LAST-1];
    assign prev_o  = sh_q[LAST];
endmodule

// File: rtl/pacc_prescaler.sv
module pacc_prescaler #(
    parameter int DIV = 64
) (
    input  logic clk,
    input  logic rst,
    input  logic run_i,
    output logic tick_o
);
    generate
        if (DIV <= 1) begin : g_passthru
            assign tick_o = run_i;
        end else begin : g_divider
            localparam int W = $clog2(DIV);
            localparam logic [W-1:0] TOP = W'(DIV - 1);

            logic [W-1:0] div_q;
            logic         at_top;

            assign at_top = (div_q == TOP);
            assign tick_o = run_i & at_top;

            always_ff @(posedge clk) begin
                if (rst || !run_i) div_q <= '0;
                else if (at_top)   div_q <= '0;
                else               div_q <= div_q + 1'b1;
            end
        end
    endgenerate
endmodule

// File: rtl/pacc_counter.sv
module pacc_counter #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         wr_i,
    input  logic [W-1:0] wdata_i,
    input  logic         inc_i,
    output logic [W-1:0] cnt_o,
    output logic         wrap_o
);
    logic [W-1:0] cnt_q;

    assign wrap_o = inc_i & ~wr_i & (&cnt_q);
    assign cnt_o  = cnt_q;

    always_ff @(posedge clk) begin
        if (rst)        cnt_q <= '0;
        else if (wr_i)  cnt_q <= wdata_i;
        else if (inc_i) cnt_q <= cnt_q + 1'b1;
    end
endmodule

// File: rtl/pulse_accum.sv
module pulse_accum
    import pacc_pkg::*;
#(
    parameter int CW       = pacc_pkg::CNT_W,
    parameter int DIVIDE   = pacc_pkg::PRESCALE,
    parameter int SYNC_STG = pacc_pkg::SYNC_DEPTH
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          timer_en_i,
    input  logic          pin_i,
    input  logic          ctrl_wr_i,
    input  logic [7:0]    ctrl_wdata_i,
    output logic [7:0]    ctrl_rdata_o,
    input  logic          cnt_wr_i,
    input  logic [CW-1:0] cnt_wdata_i,
    output logic [CW-1:0] cnt_o,
    input  logic          flag_clr_i,
    input  logic [1:0]    flag_clr_mask_i,
    output logic          ovf_flag_o,
    output logic          in_flag_o
);
    pacc_ctrl_t  ctrl_q;
    pacc_flags_t flags_q, flag_set, flag_clr;

    logic lvl, prv, tick, wrap;
    logic edge_hit, gate_now, gate_was, inc;

    always_ff @(posedge clk) begin
        if (rst)            ctrl_q <= '0;
        else if (ctrl_wr_i) ctrl_q <= ctrl_sanitize(ctrl_wdata_i);
    end
    assign ctrl_rdata_o = ctrl_q;

    pacc_sync_edge #(.STAGES(SYNC_STG)) i_sync (
        .clk(clk), .rst(rst), .pin_i(pin_i), .level_o(lvl), .prev_o(prv)
    );

    pacc_prescaler #(.DIV(DIVIDE)) i_presc (
        .clk(clk), .rst(rst), .run_i(timer_en_i), .tick_o(tick)
    );

    // Edge select: 1 = rising, 0 = falling; gate level: 0 = high, 1 = low
    assign edge_hit = ctrl_q.sel ? (lvl & ~prv) : (~lvl & prv);
    assign gate_now = lvl ^ ctrl_q.sel;
    assign gate_was = prv ^ ctrl_q.sel;

    always_comb begin
        inc = 1'b0;
        if (ctrl_q.enable) begin
            unique case (ctrl_q.mode)
                MODE_EVENT: inc = edge_hit;
                MODE_GATED: inc = gate_now & tick & timer_en_i;
                default:    inc = 1'b0;
            endcase
        end
    end

    pacc_counter #(.W(CW)) i_cnt (
        .clk(clk), .rst(rst), .wr_i(cnt_wr_i), .wdata_i(cnt_wdata_i),
        .inc_i(inc), .cnt_o(cnt_o), .wrap_o(wrap)
    );

    always_comb begin
        flag_set.ovf     = wrap;
        flag_set.in_flag = ctrl_q.enable && (ctrl_q.mode == MODE_GATED)
                           && gate_was && !gate_now;
        flag_clr.ovf     = flag_clr_i & flag_clr_mask_i[0];
        flag_clr.in_flag = flag_clr_i & flag_clr_mask_i[1];
    end

    always_ff @(posedge clk) begin
        if (rst) flags_q <= '0;
        else     flags_q <= (flags_q & ~flag_clr) | flag_set;
    end

    assign ovf_flag_o = flags_q.ovf;
    assign in_flag_o  = flags_q.in_flag;
endmodule

// File: rtl/pulse_accum_checker.sv
module pulse_accum_checker #(
    parameter int CW = 16
) (
    input logic          clk,
    input logic          rst,
    input logic          timer_en_i,
    input logic [7:0]    ctrl_rdata_o,
    input logic          cnt_wr_i,
    input logic [CW-1:0] cnt_wdata_i,
    input logic [CW-1:0] cnt_o,
    input logic          flag_clr_i,
    input logic [1:0]    flag_clr_mask_i,
    input logic          ovf_flag_o
);
    assert_rsvd_zero_R1: assert property (@(posedge clk) disable iff (rst)
        (ctrl_rdata_o[7] == 1'b0) && (ctrl_rdata_o[3:0] == 4'h0));

    assert_disabled_hold_R2: assert property (@(posedge clk) disable iff (rst)
        (!ctrl_rdata_o[6] && !cnt_wr_i) |=> $stable(cnt_o));

    // R3: without a write the count moves by at most one per cycle
    assert_single_step_R3: assert property (@(posedge clk) disable iff (rst)
        !cnt_wr_i |=> ((cnt_o == $past(cnt_o)) || (cnt_o == CW'($past(cnt_o) + 1'b1))));

    assert_gated_needs_timer_R6: assert property (@(posedge clk) disable iff (rst)
        (ctrl_rdata_o[6:5] == 2'b11 && !timer_en_i && !cnt_wr_i) |=> $stable(cnt_o));

    assert_wrap_sets_ovf_R7: assert property (@(posedge clk) disable iff (rst)
        (!cnt_wr_i && (&cnt_o)) |=> ((cnt_o == '0) -> ovf_flag_o));

    assert_ovf_sticky_R9: assert property (@(posedge clk) disable iff (rst)
        (ovf_flag_o && !(flag_clr_i && flag_clr_mask_i[0])) |=> ovf_flag_o);

    assert_write_wins_R10: assert property (@(posedge clk) disable iff (rst)
        cnt_wr_i |=> (cnt_o == $past(cnt_wdata_i)));
endmodule

bind pulse_accum pulse_accum_checker #(.CW(CW)) i_pulse_accum_checker (
    .clk(clk), .rst(rst), .timer_en_i(timer_en_i), .ctrl_rdata_o(ctrl_rdata_o),
    .cnt_wr_i(cnt_wr_i), .cnt_wdata_i(cnt_wdata_i), .cnt_o(cnt_o),
    .flag_clr_i(flag_clr_i), .flag_clr_mask_i(flag_clr_mask_i),
    .ovf_flag_o(ovf_flag_o)
);

// File: tb/test_pulse_accum.sv
module test_pulse_accum;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        timer_en_i = 1'b0;
    logic        pin_i = 1'b0;
    logic        ctrl_wr_i = 1'b0;
    logic [7:0]  ctrl_wdata_i = '0;
    logic [7:0]  ctrl_rdata_o;
    logic        cnt_wr_i = 1'b0;
    logic [15:0] cnt_wdata_i = '0;
    logic [15:0] cnt_o;
    logic        flag_clr_i = 1'b0;
    logic [1:0]  flag_clr_mask_i = '0;
    logic        ovf_flag_o, in_flag_o;

    int checks = 0;
    int errors = 0;
    string cur_req = "R1";

    always #5 clk = ~clk;

    pulse_accum i_pulse_accum (.*);

    // ---------------- behavioural reference model ----------------
    bit          pin_hist[$] = '{0, 0, 0};
    int          m_presc = 0;
    logic [7:0]  m_ctrl = '0;
    int          m_cnt = 0;
    bit          m_ovf = 0, m_inf = 0;

    always @(posedge clk) begin
        bit lvl, prv, active_now, active_was, counted, ticked, clr_o, clr_i;
        if (rst) begin
            pin_hist = '{0, 0, 0};
            m_presc = 0; m_ctrl = '0; m_cnt = 0; m_ovf = 0; m_inf = 0;
        end else begin
            lvl = pin_hist[1];
            prv = pin_hist[2];
            ticked = timer_en_i && (m_presc == 63);
            active_now = m_ctrl[4] ? !lvl : lvl;
            active_was = m_ctrl[4] ? !prv : prv;
            counted = 0;
            if (m_ctrl[6]) begin
                if (!m_ctrl[5]) counted = m_ctrl[4] ? (lvl && !prv) : (!lvl && prv);
                else            counted = active_now && ticked;
            end
            clr_o = flag_clr_i && flag_clr_mask_i[0];
            clr_i = flag_clr_i && flag_clr_mask_i[1];
            if (clr_o) m_ovf = 0;
            if (clr_i) m_inf = 0;
            if (m_ctrl[6] && m_ctrl[5] && active_was && !active_now) m_inf = 1;
            if (cnt_wr_i) m_cnt = int'(cnt_wdata_i);
            else if (counted) begin
                if (m_cnt == 65535) begin m_cnt = 0; m_ovf = 1; end
                else m_cnt = m_cnt + 1;
            end
            m_presc = !timer_en_i ? 0 : (m_presc == 63 ? 0 : m_presc + 1);
            if (ctrl_wr_i) m_ctrl = ctrl_wdata_i & 8'h70;
            pin_hist.push_front(pin_i);
            void'(pin_hist.pop_back());
        end
        #2;
        compare("count", int'(cnt_o), m_cnt);
        compare("ctrl", int'(ctrl_rdata_o), int'(m_ctrl));
        compare("ovf", int'(ovf_flag_o), int'(m_ovf));
        compare("inflag", int'(in_flag_o), int'(m_inf));
    end

    task automatic compare(input string what, input int act, input int exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s model %s: actual %0h expected %0h at %0t", cur_req, what, act, exp, $time);
        end
    endtask

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h at %0t", req, act, exp, $time);
        end
    endtask

    task automatic cycles(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic wr_ctrl(input logic [7:0] v);
        ctrl_wr_i = 1'b1; ctrl_wdata_i = v; cycles(1); ctrl_wr_i = 1'b0;
    endtask

    task automatic wr_cnt(input logic [15:0] v);
        cnt_wr_i = 1'b1; cnt_wdata_i = v; cycles(1); cnt_wr_i = 1'b0;
    endtask

    task automatic clr_flags(input logic [1:0] m);
        flag_clr_i = 1'b1; flag_clr_mask_i = m; cycles(1);
        flag_clr_i = 1'b0; flag_clr_mask_i = '0;
    endtask

    task automatic pulses(input int n);
        for (int i = 0; i < n; i++) begin
            pin_i = 1'b1; cycles(4);
            pin_i = 1'b0; cycles(4);
        end
        cycles(4);
    endtask

    // -------------------- watchdog --------------------
    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: run did not complete");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    // -------------------- stimulus --------------------
    initial begin
        cycles(4);
        rst = 1'b0;
        cycles(1);
        check("R1", int'(ctrl_rdata_o), 0);
        check("R1", int'(cnt_o), 0);
        check("R7", int'(ovf_flag_o), 0);

        // R1: reserved and unused bits ignore writes
        wr_ctrl(8'hFF); cycles(1);
        check("R1", int'(ctrl_rdata_o), 'h70);
        wr_ctrl(8'h00);

        // R2: disabled, pin activity ignored
        cur_req = "R2";
        pulses(5);
        check("R2", int'(cnt_o), 0);

        // R3 / R4: rising edges with timer disabled
        cur_req = "R4";
        wr_ctrl(8'h50);
        pulses(6);
        check("R4", int'(cnt_o), 6);

        // R3: falling edges, latency of three clocks
        cur_req = "R3";
        wr_ctrl(8'h40);
        pulses(3);
        check("R3", int'(cnt_o), 9);
        pin_i = 1'b1; cycles(1); pin_i = 1'b0;
        cycles(2);
        check("R3", int'(cnt_o), 9);
        cycles(1);
        check("R3", int'(cnt_o), 10);
        cycles(4);

        // R5: gated, active high, exactly four ticks
        cur_req = "R5";
        wr_cnt(16'h0000);
        wr_ctrl(8'h60);
        timer_en_i = 1'b1; pin_i = 1'b1;
        cycles(266);
        pin_i = 1'b0;
        cycles(5);
        check("R5", int'(cnt_o), 4);
        check("R8", int'(in_flag_o), 1);

        // R9: clear only the input flag
        cur_req = "R9";
        clr_flags(2'b01);
        check("R9", int'(in_flag_o), 1);
        clr_flags(2'b10);
        check("R9", int'(in_flag_o), 0);

        // R5: gated, active low
        cur_req = "R5";
        ctrl_wr_i = 1'b1; ctrl_wdata_i = 8'h70;
        cnt_wr_i = 1'b1; cnt_wdata_i = 16'h0000;
        cycles(1);
        ctrl_wr_i = 1'b0; cnt_wr_i = 1'b0;
        cycles(256);
        pin_i = 1'b1;
        cycles(5);
        check("R5", int'(cnt_o >= 16'd4 && cnt_o <= 16'd5), 1);
        check("R8", int'(in_flag_o), 1);

        // R6: gated with timer disabled, gate open (pin low)
        cur_req = "R6";
        pin_i = 1'b0; timer_en_i = 1'b0;
        wr_cnt(16'h0042);
        cycles(200);
        check("R6", int'(cnt_o), 'h42);
        clr_flags(2'b10);

        // R7: wrap sets overflow
        cur_req = "R7";
        wr_ctrl(8'h50);
        wr_cnt(16'hFFFE);
        pulses(1);
        check("R7", int'(cnt_o), 'hFFFF);
        check("R7", int'(ovf_flag_o), 0);
        pulses(1);
        check("R7", int'(cnt_o), 0);
        check("R7", int'(ovf_flag_o), 1);
        clr_flags(2'b01);
        check("R9", int'(ovf_flag_o), 0);

        // R10: write collides with a counted edge at 0xFFFF
        cur_req = "R10";
        wr_cnt(16'hFFFF);
        pin_i = 1'b1;
        cycles(2);
        cnt_wr_i = 1'b1; cnt_wdata_i = 16'h1234;
        cycles(1);
        cnt_wr_i = 1'b0;
        check("R10", int'(cnt_o), 'h1234);
        check("R10", int'(ovf_flag_o), 0);
        pin_i = 1'b0; cycles(4);

        // R9: overflow set beats a clear in the same cycle
        cur_req = "R9";
        wr_cnt(16'hFFFF);
        pin_i = 1'b1;
        cycles(2);
        flag_clr_i = 1'b1; flag_clr_mask_i = 2'b01;
        cycles(1);
        flag_clr_i = 1'b0; flag_clr_mask_i = '0;
        check("R9", int'(cnt_o), 0);
        check("R9", int'(ovf_flag_o), 1);
        pin_i = 1'b0; cycles(4);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule